// File: doc/BRIEF.md
# Conflict-Aware Node Task Scheduler

This block keeps a small queue of tree-node training jobs that are waiting to run or already running. Each job has a node identifier and a mask of the compute partitions it will occupy. Every cycle the scheduler looks for the oldest waiting job whose partitions are all idle. When the number of running jobs is below the number of score units, it launches that job. Launching a job reserves its partitions in a busy mask. Completing the job releases them. Jobs with disjoint partition sets therefore train side by side. A job that would collide with a running one waits, and younger jobs that do not collide may pass it.

Software or a control engine pushes jobs through the insert port. It reads launches from the dispatch port and reports finished nodes through the completion port. The busy mask is visible at all times. When the queue holds its full capacity, the full flag rises and further inserts are dropped.

Top module: `node_task_sched`

## Requirements
- R1: After a synchronous active-low reset the queue is empty, `busy_mask` is 0, `disp_valid` is low and `ins_full` is low.
- R2: A job is launched only if its partition mask ANDed with the busy mask of the deciding cycle is zero. Bit k of each mask stands for partition k. Masks 0x53 and 0x0C may run together, and 0xE5 overlaps 0x53.
- R3: A launch shows in the cycle after the decision. For that one cycle `disp_valid` is high and `disp_node_id`/`disp_mask` carry the job. In the same cycle `busy_mask` includes the job's mask bits.
- R4: Among waiting, non-conflicting jobs, the one inserted earliest is launched. A younger job may overtake an older one that conflicts.
- R5: At most one launch per cycle. No launch occurs while the number of running jobs equals NUM_SCORE_UNITS (default 2).
- R6: A completion naming a running job clears that job's bits from `busy_mask` on the next edge and removes the job from the queue. This frees its slot.
- R7: `ins_full` is high exactly when NUM_ENTRIES (default 8) jobs are queued. An insert while full is dropped and leaves the queue unchanged.
- R8: A completion whose ID matches no running job has no effect. This covers an ID still waiting and an ID never inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert a job this cycle |
| ins_node_id | input | ID_W | Node ID of the inserted job |
| ins_mask | input | NUM_PARTS | Partitions the inserted job needs |
| ins_full | output | 1 | Queue full; inserts are dropped |
| disp_valid | output | 1 | One-cycle launch strobe |
| disp_node_id | output | ID_W | Node ID of the launched job |
| disp_mask | output | NUM_PARTS | Partition mask of the launched job |
| done_valid | input | 1 | Completion report this cycle |
| done_node_id | input | ID_W | Node ID that finished |
| busy_mask | output | NUM_PARTS | Partitions currently reserved |

## Verification
The bench targets the following cases, each paired with the failure it would expose:

- An older job blocked by a conflict while a younger disjoint job waits behind it. A strict in-order queue would stall here.
- The score-unit limit reached while an idle-partition job waits. A missing limit would launch a third job.
- Completions naming waiting or unknown IDs. A sloppy match would corrupt the busy mask or drop a queued job.
- Inserts into a full queue, alone and in the same cycle as a completion. A miscounted tail would overwrite a live job.

// File: rtl/nts_pkg.sv
// Package: shared defaults for the node task scheduler.
// Assumes: every parameter of the scheduler is derived from these values.
package nts_pkg;
    localparam int NTS_PARTS   = 8;
    localparam int NTS_ENTRIES = 8;
    localparam int NTS_UNITS   = 2;
    localparam int NTS_ID_W    = 8;
endpackage

// File: rtl/nts_first_set.sv
// Module: lowest-index finder over a request vector.
// Does: reports whether any bit is set and the index of the lowest set bit.
// Assumes: lower index means higher priority (older queue slot).
module nts_first_set #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit is the one that sticks.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/nts_store.sv
// Module: compacting job queue.
// Does: holds jobs in insertion order (slot 0 oldest). Removing a slot shifts
//       younger jobs down, and inserts go to the tail.
// Assumes: ins_en only when not full; run_idx points to a valid waiting slot;
//          rm_idx points to a valid running slot distinct from run_idx.
module nts_store #(
    parameter int N     = 8,
    parameter int PARTS = 8,
    parameter int ID_W  = 8,
    parameter int IDX_W = $clog2(N),
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ins_en,
    input  logic [ID_W-1:0]          ins_id,
    input  logic [PARTS-1:0]         ins_mask,
    input  logic                     run_en,
    input  logic [IDX_W-1:0]         run_idx,
    input  logic                     rm_en,
    input  logic [IDX_W-1:0]         rm_idx,
    output logic [N-1:0]             vld,
    output logic [N-1:0]             run,
    output logic [N-1:0][ID_W-1:0]   ids,
    output logic [N-1:0][PARTS-1:0]  masks,
    output logic [CNT_W-1:0]         cnt
);
    logic [N-1:0]            vld_n, run_n;
    logic [N-1:0][ID_W-1:0]  ids_n;
    logic [N-1:0][PARTS-1:0] masks_n;
    logic [CNT_W-1:0]        cnt_n, tail;

    // Next queue contents: mark the launch, compact out the removal, append.
    always_comb begin
        vld_n   = vld;
        run_n   = run;
        ids_n   = ids;
        masks_n = masks;
        if (run_en) run_n[run_idx] = 1'b1;
        if (rm_en) begin
            for (int i = 0; i < N - 1; i++) begin
                if (IDX_W'(i) >= rm_idx) begin
                    vld_n[i]   = vld_n[i+1];
                    run_n[i]   = run_n[i+1];
                    ids_n[i]   = ids_n[i+1];
                    masks_n[i] = masks_n[i+1];
                end
            end
            vld_n[N-1] = 1'b0;
            run_n[N-1] = 1'b0;
        end
        tail  = cnt - CNT_W'(rm_en);
        cnt_n = tail + CNT_W'(ins_en);
        if (ins_en) begin
            vld_n[tail[IDX_W-1:0]]   = 1'b1;
            run_n[tail[IDX_W-1:0]]   = 1'b0;
            ids_n[tail[IDX_W-1:0]]   = ins_id;
            masks_n[tail[IDX_W-1:0]] = ins_mask;
        end
    end

    // Queue state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld   <= '0;
            run   <= '0;
            ids   <= '0;
            masks <= '0;
            cnt   <= '0;
        end else begin
            vld   <= vld_n;
            run   <= run_n;
            ids   <= ids_n;
            masks <= masks_n;
            cnt   <= cnt_n;
        end
    end
endmodule

// File: rtl/node_task_sched.sv
// Module: conflict-aware node task scheduler (top).
// Does: launches the oldest waiting job whose partitions are idle, at most one
//       per cycle and never beyond the score-unit count. Partitions are reserved
//       on launch and released on completion.
// Assumes: node IDs of running jobs are unique; a completion frees the lowest
//          matching running slot.
module node_task_sched #(
    parameter int NUM_PARTS       = nts_pkg::NTS_PARTS,
    parameter int NUM_ENTRIES     = nts_pkg::NTS_ENTRIES,
    parameter int NUM_SCORE_UNITS = nts_pkg::NTS_UNITS,
    parameter int ID_W            = nts_pkg::NTS_ID_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ins_valid,
    input  logic [ID_W-1:0]      ins_node_id,
    input  logic [NUM_PARTS-1:0] ins_mask,
    output logic                 ins_full,
    output logic                 disp_valid,
    output logic [ID_W-1:0]      disp_node_id,
    output logic [NUM_PARTS-1:0] disp_mask,
    input  logic                 done_valid,
    input  logic [ID_W-1:0]      done_node_id,
    output logic [NUM_PARTS-1:0] busy_mask
);
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam int CNT_W = $clog2(NUM_ENTRIES + 1);

    logic [NUM_ENTRIES-1:0]                vld, run, elig, hit;
    logic [NUM_ENTRIES-1:0][ID_W-1:0]      ids;
    logic [NUM_ENTRIES-1:0][NUM_PARTS-1:0] masks;
    logic [CNT_W-1:0]                      cnt, run_cnt;
    logic                                  pick_found, hit_found, ins_en, slot_free;
    logic [IDX_W-1:0]                      pick_idx, hit_idx;
    logic [NUM_PARTS-1:0]                  busy_n;

    assign ins_full  = (cnt == CNT_W'(NUM_ENTRIES));
    assign ins_en    = ins_valid && !ins_full;

    // Count running jobs to enforce the score-unit limit.
    always_comb begin
        run_cnt = '0;
        for (int i = 0; i < NUM_ENTRIES; i++)
            run_cnt = run_cnt + CNT_W'(vld[i] & run[i]);
    end

    assign slot_free = (run_cnt < CNT_W'(NUM_SCORE_UNITS));

    // Per-slot launch eligibility and completion match.
    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
            assign elig[g] = vld[g] && !run[g] && slot_free
                             && ((masks[g] & busy_mask) == '0);
            assign hit[g]  = done_valid && vld[g] && run[g]
                             && (ids[g] == done_node_id);
        end
    endgenerate

    nts_first_set #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick (
        .req(elig), .found(pick_found), .idx(pick_idx));

    nts_first_set #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_hit (
        .req(hit), .found(hit_found), .idx(hit_idx));

    nts_store #(
        .N(NUM_ENTRIES), .PARTS(NUM_PARTS), .ID_W(ID_W),
        .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .ins_en(ins_en), .ins_id(ins_node_id), .ins_mask(ins_mask),
        .run_en(pick_found), .run_idx(pick_idx),
        .rm_en(hit_found), .rm_idx(hit_idx),
        .vld(vld), .run(run), .ids(ids), .masks(masks), .cnt(cnt)
    );

    // Next busy mask: release the finished job, reserve the launched one.
    always_comb begin
        busy_n = busy_mask;
        if (hit_found)  busy_n = busy_n & ~masks[hit_idx];
        if (pick_found) busy_n = busy_n | masks[pick_idx];
    end

    // Busy mask and one-cycle launch strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_mask    <= '0;
            disp_valid   <= 1'b0;
            disp_node_id <= '0;
            disp_mask    <= '0;
        end else begin
            busy_mask  <= busy_n;
            disp_valid <= pick_found;
            if (pick_found) begin
                disp_node_id <= ids[pick_idx];
                disp_mask    <= masks[pick_idx];
            end
        end
    end
endmodule

// File: rtl/nts_checker.sv
// Module: protocol checker for node_task_sched, attached with bind below.
// Does: checks reset state, disjointness, reservation, unit limit and full rule.
// Assumes: run_cnt is the number of running jobs inside the scheduler.
module nts_checker #(
    parameter int NUM_PARTS = 8,
    parameter int NUM_UNITS = 2,
    parameter int CNT_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ins_valid,
    input logic                 ins_full,
    input logic                 done_valid,
    input logic                 disp_valid,
    input logic [NUM_PARTS-1:0] disp_mask,
    input logic [NUM_PARTS-1:0] busy_mask,
    input logic [CNT_W-1:0]     run_cnt
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!disp_valid && busy_mask == '0 && !ins_full)); // R1

    AST_DISJOINT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> ((disp_mask & $past(busy_mask)) == '0)); // R2

    AST_LAUNCH_RESERVES: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> ((busy_mask & disp_mask) == disp_mask)); // R3

    AST_UNIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CNT_W'(NUM_UNITS)); // R5

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_full && !done_valid) |=> ins_full); // R7
endmodule

bind node_task_sched nts_checker #(
    .NUM_PARTS(NUM_PARTS), .NUM_UNITS(NUM_SCORE_UNITS), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_full(ins_full),
    .done_valid(done_valid), .disp_valid(disp_valid), .disp_mask(disp_mask),
    .busy_mask(busy_mask), .run_cnt(run_cnt)
);

// File: tb/node_task_sched_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random traffic, all compared
// against a queue model written from the requirements.
module node_task_sched_tb;
    localparam int P  = 8;
    localparam int N  = 8;
    localparam int SU = 2;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ins_valid = 1'b0, done_valid = 1'b0;
    logic [IW-1:0] ins_node_id = '0, done_node_id = '0;
    logic [P-1:0]  ins_mask = '0;
    logic          ins_full, disp_valid;
    logic [IW-1:0] disp_node_id;
    logic [P-1:0]  disp_mask, busy_mask;

    int tests = 0, fails = 0;

    // Model state.
    int          m_cnt = 0;
    bit          m_run [N];
    logic [IW-1:0] m_id [N];
    logic [P-1:0]  m_mask [N];
    logic [P-1:0]  m_busy = '0;
    bit          m_dv = 0;
    logic [IW-1:0] m_did = '0;
    logic [P-1:0]  m_dmask = '0;
    logic [IW-1:0] next_id = 8'd1;

    always #2.5 clk = ~clk;

    node_task_sched u_dut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_node_id(ins_node_id), .ins_mask(ins_mask),
        .ins_full(ins_full), .disp_valid(disp_valid), .disp_node_id(disp_node_id),
        .disp_mask(disp_mask), .done_valid(done_valid), .done_node_id(done_node_id),
        .busy_mask(busy_mask)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Next model state from the current state and this cycle's inputs.
    task automatic model_step(input bit iv, input logic [IW-1:0] iid,
                              input logic [P-1:0] im, input bit dv,
                              input logic [IW-1:0] did);
        int p = -1, r = -1, rc = 0;
        bit full = (m_cnt == N);
        logic [P-1:0] nb = m_busy;
        for (int i = 0; i < m_cnt; i++) if (m_run[i]) rc++;
        if (rc < SU)
            for (int i = 0; i < m_cnt; i++)
                if (p < 0 && !m_run[i] && (m_mask[i] & m_busy) == '0) p = i;
        if (dv)
            for (int i = 0; i < m_cnt; i++)
                if (r < 0 && m_run[i] && m_id[i] == did) r = i;
        if (r >= 0) nb = nb & ~m_mask[r];
        m_dv = (p >= 0);
        if (p >= 0) begin
            nb = nb | m_mask[p];
            m_did = m_id[p];
            m_dmask = m_mask[p];
            m_run[p] = 1'b1;
        end
        if (r >= 0) begin
            for (int i = r; i < N - 1; i++) begin
                m_run[i] = m_run[i+1]; m_id[i] = m_id[i+1]; m_mask[i] = m_mask[i+1];
            end
            m_cnt--;
        end
        if (iv && !full) begin
            m_run[m_cnt] = 1'b0; m_id[m_cnt] = iid; m_mask[m_cnt] = im;
            m_cnt++;
        end
        m_busy = nb;
    endtask

    // Compare every output against the model (called away from the edge).
    task automatic compare_all();
        check(disp_valid == m_dv, "R5 disp_valid", 32'(disp_valid), 32'(m_dv));
        if (m_dv) begin
            check(disp_node_id == m_did, "R4 disp_node_id", 32'(disp_node_id), 32'(m_did));
            check(disp_mask == m_dmask, "R3 disp_mask", 32'(disp_mask), 32'(m_dmask));
        end
        check(busy_mask == m_busy, "R6 busy_mask", 32'(busy_mask), 32'(m_busy));
        check(ins_full == (m_cnt == N), "R7 ins_full", 32'(ins_full), 32'(m_cnt == N));
    endtask

    // One clock: drive at the falling edge, update model, sample at next fall.
    task automatic cyc(input bit iv, input logic [IW-1:0] iid, input logic [P-1:0] im,
                       input bit dv, input logic [IW-1:0] did);
        ins_valid = iv; ins_node_id = iid; ins_mask = im;
        done_valid = dv; done_node_id = did;
        model_step(iv, iid, im, dv, did);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        cyc(1'b0, '0, '0, 1'b0, '0);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(!disp_valid && busy_mask == '0 && !ins_full, "R1 reset state",
              {disp_valid, ins_full, 22'd0, busy_mask}, 32'd0);

        // R2/R4: A=0x53, B=0x0C disjoint, C=0xE5 overlaps A.
        cyc(1'b1, 8'hA1, 8'h53, 1'b0, '0);
        cyc(1'b1, 8'hB2, 8'h0C, 1'b0, '0);
        check(disp_valid && disp_node_id == 8'hA1, "R3 first launch", 32'(disp_node_id), 32'hA1);
        cyc(1'b1, 8'hC3, 8'hE5, 1'b0, '0);
        check(disp_valid && disp_node_id == 8'hB2, "R2 disjoint pair", 32'(disp_node_id), 32'hB2);
        idle();
        check(busy_mask == 8'h5F && !disp_valid, "R2 conflict held", 32'(busy_mask), 32'h5F);
        // R8: completing a waiting job or an unknown ID changes nothing.
        cyc(1'b0, '0, '0, 1'b1, 8'hC3);
        check(busy_mask == 8'h5F, "R8 waiting id", 32'(busy_mask), 32'h5F);
        cyc(1'b0, '0, '0, 1'b1, 8'h77);
        check(busy_mask == 8'h5F, "R8 unknown id", 32'(busy_mask), 32'h5F);
        // R5: D=0x20 is disjoint but both units are busy.
        cyc(1'b1, 8'hD4, 8'h20, 1'b0, '0);
        idle();
        check(!disp_valid, "R5 unit limit", 32'(disp_valid), 32'd0);
        // R6/R4: finishing A frees a unit; C still overlaps B so D overtakes.
        cyc(1'b0, '0, '0, 1'b1, 8'hA1);
        check(busy_mask == 8'h0C, "R6 release", 32'(busy_mask), 32'h0C);
        idle();
        check(disp_valid && disp_node_id == 8'hD4, "R4 younger overtakes",
              32'(disp_node_id), 32'hD4);
        cyc(1'b0, '0, '0, 1'b1, 8'hB2);
        cyc(1'b0, '0, '0, 1'b1, 8'hD4);
        idle();
        check(disp_valid && disp_node_id == 8'hC3, "R4 blocked job resumes",
              32'(disp_node_id), 32'hC3);
        // R7: fill with jobs that all need partition 0 (C holds it).
        for (int k = 0; k < N + 2; k++) cyc(1'b1, 8'h10 + 8'(k), 8'h01, 1'b0, '0);
        check(ins_full, "R7 full", 32'(ins_full), 32'd1);
        cyc(1'b1, 8'h99, 8'h02, 1'b1, 8'hC3);
        check(ins_full == (m_cnt == N), "R7 insert with completion while full",
              32'(ins_full), 32'(m_cnt == N));

        // Random phase.
        for (int t = 0; t < 4000; t++) begin
            bit iv = ($urandom % 2) == 0;
            logic [P-1:0] im = 8'($urandom) & 8'($urandom);
            bit dv = 1'b0;
            logic [IW-1:0] did = 8'($urandom);
            int sel = $urandom % 4;
            if (sel < 2) begin
                int nr = 0;
                for (int i = 0; i < m_cnt; i++) if (m_run[i]) nr++;
                if (nr > 0) begin
                    int pick = $urandom % nr;
                    for (int i = 0; i < m_cnt; i++)
                        if (m_run[i]) begin
                            if (pick == 0) did = m_id[i];
                            pick--;
                        end
                    dv = 1'b1;
                end
            end else if (sel == 2) begin
                dv = 1'b1;
            end
            cyc(iv, next_id, im, dv, did);
            if (iv) next_id++;
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule